// File: doc/BRIEF.md
# Modulo-interleaved memory bank mapper

This block turns a flat word address into a bank index and a position inside that bank, for a memory split across a prime number of banks. The bank count has the form 2^k−1 (3, 7, 31, ...) and each bank holds a power-of-two number of words. Because the two sizes share no factor, taking the address modulo each of them gives a unique pair for every address up to their product. This lets consecutive and strided accesses spread over the banks without a divider on the fast path. A power-of-two bank count would send every stride that is a multiple of the bank count to a single bank.

A request carries an address and a mode bit. In modulo mode the in-bank position is simply the low address bits, and the bank index comes from a residue fold with end-around carry, so the response is due one cycle after acceptance. In sequential mode the position is the address divided by the bank count. A small restoring divider produces it over several cycles, and the request handshake stays closed while the divider works. Addresses past the end of the memory are flagged and return zero fields.

Top module: `mbm_mapper`

## Requirements
- R1: After reset, `rsp_valid` is low and `req_ready` is high.
- R2: With `req_seq`=0 (modulo mode) and an address below NB·WB, the response one cycle after acceptance has bank = address mod NB and offset = address mod WB. With NB=3 and WB=8: 16→(1,0), 8→(2,0), 9→(0,1), 1→(1,1).
- R3: The bank index never equals the all-ones value NB. Addresses that are multiples of NB, such as 3 and 21, give bank 0.
- R4: In modulo mode, every address 0..NB·WB−1 maps to a different (bank, offset) pair, so every pair is used exactly once.
- R5: With `req_seq`=1 (sequential mode) and an in-range address, the response arrives OFFS_BITS cycles after acceptance, with bank = address mod NB and offset = address / NB. Addresses 0, 1 and 2 go to offset 0 of banks 0, 1 and 2.
- R6: From the cycle after a sequential-mode acceptance until the response cycle, `req_ready` is low and `rsp_valid` is low. A request held during that window is not taken and yields no response.
- R7: An address of NB·WB or more gives `rsp_oor`=1 with bank 0 and offset 0, one cycle after acceptance, in either mode.
- R8: Each accepted request yields exactly one single-cycle `rsp_valid` pulse. With no request, `rsp_valid` stays low.
- R9: Modulo-mode and out-of-range requests can be accepted on every cycle. `req_ready` stays high and each response follows its request by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | ADDR_W | Flat word address |
| req_seq | input | 1 | 0: modulo mapping, 1: sequential mapping |
| rsp_valid | output | 1 | Response pulse |
| rsp_bank | output | BANK_BITS | Bank index |
| rsp_offset | output | OFFS_BITS | Word position inside the bank |
| rsp_oor | output | 1 | Address past the end of the memory |

## Verification
Modulo-mode and out-of-range results are due on the cycle after the accepting edge. Sequential results are due OFFS_BITS edges after it. The bench drives on falling edges and samples on the falling edge that follows the edge where each result must appear, for each case. During the divider's busy cycles it checks ready and valid on every falling edge. On the cycle after each response it checks that no second pulse follows. Back-to-back modulo traffic is checked one response per cycle, and expected values come from plain modulo and division in bench functions.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DIV  = 1'b1
    } mbm_state_e;

    localparam logic MODE_MOD = 1'b0;
    localparam logic MODE_SEQ = 1'b1;

endpackage

// File: rtl/mbm_fold.sv
// Residue of an unsigned value modulo 2^K-1 by summing K-bit slices
// with end-around carry; the all-ones result is the same class as zero.
module mbm_fold #(
    parameter int K = 2,
    parameter int W = 8
) (
    input  logic [W-1:0] value,
    output logic [K-1:0] residue
);
    localparam int NCH  = (W + K - 1) / K;
    localparam int PADW = NCH * K;

    logic [PADW-1:0] padded;
    logic [K-1:0]    acc [NCH+1];

    assign padded = PADW'(value);
    assign acc[0] = '0;

    for (genvar g = 0; g < NCH; g++) begin : g_slice
        logic [K:0] sum;
        assign sum      = {1'b0, acc[g]} + {1'b0, padded[g*K +: K]};
        assign acc[g+1] = sum[K-1:0] + {{(K-1){1'b0}}, sum[K]};
    end

    assign residue = (&acc[NCH]) ? '0 : acc[NCH];
endmodule

// File: rtl/mbm_divstep.sv
// One restoring-division step against (2^K-1) shifted left by 'shift'.
module mbm_divstep #(
    parameter int K  = 2,
    parameter int AW = 8,
    parameter int SW = 2
) (
    input  logic [AW-1:0] rem_in,
    input  logic [SW-1:0] shift,
    output logic [AW-1:0] rem_out,
    output logic          take
);
    localparam logic [AW-1:0] DIVISOR = AW'((1 << K) - 1);

    logic [AW-1:0] shifted;

    assign shifted = DIVISOR << shift;
    assign take    = (rem_in >= shifted);
    assign rem_out = take ? (rem_in - shifted) : rem_in;
endmodule

// File: rtl/mbm_mapper.sv
module mbm_mapper
    import mbm_pkg::*;
#(
    parameter int BANK_BITS = 2,
    parameter int OFFS_BITS = 3,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_seq,
    output logic                 rsp_valid,
    output logic [BANK_BITS-1:0] rsp_bank,
    output logic [OFFS_BITS-1:0] rsp_offset,
    output logic                 rsp_oor
);
    localparam int NB    = (1 << BANK_BITS) - 1;
    localparam int WB    = 1 << OFFS_BITS;
    localparam int TOTAL = NB * WB;
    localparam int SW    = (OFFS_BITS > 1) ? $clog2(OFFS_BITS) : 1;

    typedef struct packed {
        mbm_state_e             st;
        logic [ADDR_W-1:0]      rem;
        logic [OFFS_BITS-1:0]   quo;
        logic [SW-1:0]          step;
        logic [BANK_BITS-1:0]   bank_hold;
        logic                   rsp_valid;
        logic [BANK_BITS-1:0]   bank;
        logic [OFFS_BITS-1:0]   offset;
        logic                   oor;
    } regs_t;

    localparam regs_t REGS_RST = '0;

    regs_t r_d, r_q;

    logic [BANK_BITS-1:0] fold_bank;
    logic [ADDR_W-1:0]    step_rem;
    logic                 step_take;
    logic                 in_range;
    logic                 accept;

    mbm_fold #(
        .K (BANK_BITS),
        .W (ADDR_W)
    ) u_fold (
        .value   (req_addr),
        .residue (fold_bank)
    );

    mbm_divstep #(
        .K  (BANK_BITS),
        .AW (ADDR_W),
        .SW (SW)
    ) u_divstep (
        .rem_in  (r_q.rem),
        .shift   (r_q.step),
        .rem_out (step_rem),
        .take    (step_take)
    );

    assign in_range  = ({1'b0, req_addr} < (ADDR_W + 1)'(TOTAL));
    assign req_ready = (r_q.st == ST_IDLE);
    assign accept    = req_valid && req_ready;

    always_comb begin
        r_d           = r_q;
        r_d.rsp_valid = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (!in_range) begin
                        r_d.rsp_valid = 1'b1;
                        r_d.oor       = 1'b1;
                        r_d.bank      = '0;
                        r_d.offset    = '0;
                    end else if (req_seq == MODE_MOD) begin
                        r_d.rsp_valid = 1'b1;
                        r_d.oor       = 1'b0;
                        r_d.bank      = fold_bank;
                        r_d.offset    = req_addr[OFFS_BITS-1:0];
                    end else begin
                        r_d.st        = ST_DIV;
                        r_d.rem       = req_addr;
                        r_d.quo       = '0;
                        r_d.step      = SW'(OFFS_BITS - 1);
                        r_d.bank_hold = fold_bank;
                    end
                end
            end
            ST_DIV: begin
                r_d.rem             = step_rem;
                r_d.quo[r_q.step]   = step_take;
                if (r_q.step == '0) begin
                    r_d.st        = ST_IDLE;
                    r_d.rsp_valid = 1'b1;
                    r_d.oor       = 1'b0;
                    r_d.bank      = r_q.bank_hold;
                    r_d.offset    = r_d.quo;
                end else begin
                    r_d.step = r_q.step - SW'(1);
                end
            end
            default: r_d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_valid  = r_q.rsp_valid;
    assign rsp_bank   = r_q.bank;
    assign rsp_offset = r_q.offset;
    assign rsp_oor    = r_q.oor;
endmodule

// File: rtl/mbm_mapper_chk.sv
module mbm_mapper_chk #(
    parameter int BANK_BITS = 2,
    parameter int OFFS_BITS = 3,
    parameter int ADDR_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [ADDR_W-1:0]    req_addr,
    input logic                 req_seq,
    input logic                 rsp_valid,
    input logic [BANK_BITS-1:0] rsp_bank,
    input logic [OFFS_BITS-1:0] rsp_offset,
    input logic                 rsp_oor
);
    localparam int NB    = (1 << BANK_BITS) - 1;
    localparam int TOTAL = NB * (1 << OFFS_BITS);

    logic take_in, take_out;
    assign take_in  = req_valid && req_ready && (int'(req_addr) < TOTAL);
    assign take_out = req_valid && req_ready && (int'(req_addr) >= TOTAL);

    // R2
    mod_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_in && !req_seq) |=> (rsp_valid && !rsp_oor &&
            rsp_offset == $past(req_addr[OFFS_BITS-1:0])));

    // R3
    bank_reduced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_bank != BANK_BITS'(NB)));

    // R6
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_in && req_seq) |=> (!req_ready && !rsp_valid));

    // R7
    oor_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_out |=> (rsp_valid && rsp_oor));

    // R7
    oor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_oor) |-> (rsp_bank == '0 && rsp_offset == '0));

    // R8
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);
endmodule

bind mbm_mapper mbm_mapper_chk #(
    .BANK_BITS (BANK_BITS),
    .OFFS_BITS (OFFS_BITS),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_seq    (req_seq),
    .rsp_valid  (rsp_valid),
    .rsp_bank   (rsp_bank),
    .rsp_offset (rsp_offset),
    .rsp_oor    (rsp_oor)
);

// File: tb/mbm_mapper_bench.sv
module mbm_mapper_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BB    = 2;
    localparam int OB    = 3;
    localparam int AW    = 8;
    localparam int NB    = (1 << BB) - 1;
    localparam int WB    = 1 << OB;
    localparam int TOTAL = NB * WB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          req_seq = 1'b0;
    logic          rsp_valid;
    logic [BB-1:0] rsp_bank;
    logic [OB-1:0] rsp_offset;
    logic          rsp_oor;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mbm_mapper #(.BANK_BITS(BB), .OFFS_BITS(OB), .ADDR_W(AW)) u_mbm_mapper (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_seq    (req_seq),
        .rsp_valid  (rsp_valid),
        .rsp_bank   (rsp_bank),
        .rsp_offset (rsp_offset),
        .rsp_oor    (rsp_oor)
    );

    function automatic int exp_bank(int a);
        return (a < TOTAL) ? (a % NB) : 0;
    endfunction

    function automatic int exp_off(int a, bit seq);
        if (a >= TOTAL) return 0;
        return seq ? (a / NB) : (a % WB);
    endfunction

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_rsp(string req, int a, bit seq);
        check({req, " valid"}, int'(rsp_valid), 1);
        check({req, " oor"}, int'(rsp_oor), (a >= TOTAL) ? 1 : 0);
        check({req, " bank"}, int'(rsp_bank), exp_bank(a));
        check({req, " offset"}, int'(rsp_offset), exp_off(a, seq));
    endtask

    // One request; hold_busy keeps a stray request up during divider cycles.
    task automatic send(int a, bit seq, bit hold_busy);
        string tag;
        @(negedge clk);
        check("R6 ready before request", int'(req_ready), 1);
        req_valid = 1'b1;
        req_addr  = AW'(a);
        req_seq   = seq;
        @(negedge clk);
        if (seq && a < TOTAL) begin
            if (hold_busy) req_addr = AW'(200);
            else req_valid = 1'b0;
            for (int c = 0; c < OB; c++) begin
                check("R6 ready low while dividing", int'(req_ready), 0);
                check("R6 no response while dividing", int'(rsp_valid), 0);
                @(negedge clk);
            end
            req_valid = 1'b0;
            tag = "R5";
        end else begin
            req_valid = 1'b0;
            tag = (a >= TOTAL) ? "R7" : "R2";
        end
        check_rsp(tag, a, seq);
        @(negedge clk);
        check("R8 single pulse", int'(rsp_valid), 0);
    endtask

    initial begin
        int seen [TOTAL];
        int prev;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 valid after reset", int'(rsp_valid), 0);
        check("R1 ready after reset", int'(req_ready), 1);

        // R2 directed points
        send(16, 1'b0, 1'b0);
        send(8, 1'b0, 1'b0);
        send(9, 1'b0, 1'b0);
        send(1, 1'b0, 1'b0);
        // R3 multiples of NB fold to bank 0
        send(3, 1'b0, 1'b0);
        send(21, 1'b0, 1'b0);
        // R5 sequential directed
        send(0, 1'b1, 1'b0);
        send(1, 1'b1, 1'b0);
        send(2, 1'b1, 1'b0);
        send(TOTAL - 1, 1'b1, 1'b0);
        // R6 stray request held during busy cycles
        send(17, 1'b1, 1'b1);
        // R7 boundary and top
        send(TOTAL, 1'b0, 1'b0);
        send(TOTAL, 1'b1, 1'b0);
        send(255, 1'b1, 1'b0);
        send(TOTAL - 1, 1'b0, 1'b0);

        // R9 back-to-back modulo traffic over all addresses, R4 uniqueness
        foreach (seen[i]) seen[i] = 0;
        prev = -1;
        for (int i = 0; i <= TOTAL; i++) begin
            @(negedge clk);
            if (prev >= 0) begin
                check_rsp("R9", prev, 1'b0);
                check("R9 ready stays high", int'(req_ready), 1);
                if (!rsp_oor) seen[int'(rsp_bank) * WB + int'(rsp_offset)]++;
            end
            if (i < TOTAL) begin
                req_valid = 1'b1;
                req_addr  = AW'(i);
                req_seq   = 1'b0;
                prev      = i;
            end else begin
                req_valid = 1'b0;
            end
        end
        for (int p = 0; p < TOTAL; p++) check("R4 pair used once", seen[p], 1);

        // Mixed random traffic
        for (int n = 0; n < 300; n++) begin
            int a;
            a = ($urandom % 4 == 0) ? int'($urandom % 256) : int'($urandom % TOTAL);
            send(a, 1'($urandom), 1'($urandom));
        end

        // R8 idle line stays quiet
        repeat (5) begin
            @(negedge clk);
            check("R8 idle no response", int'(rsp_valid), 0);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule